// File: doc/BRIEF.md
# Burst Address Counter

This block holds the address that one port of a synchronous memory presents to its array. On each rising clock edge it either clears the address to zero, captures an address from outside, keeps the address it already has, or steps to the next location. Stepping lets a master start a burst with a single external address and then walk through consecutive locations without driving new addresses.

Three active-low controls choose the action. They follow a fixed priority: clear, then load, then count, then hold. The counter has no view of chip select or write control. It loads and advances on every qualifying edge, whether or not the port is selected. The address is a registered output, so the array sees it in the same cycle as the port's other registered controls. At the top of the address space, stepping wraps to zero.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_q` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst` low and `clear_n` low at a rising edge, `addr_q` becomes 0 after that edge, whatever `load_n`, `count_n` and `ext_addr` are.
- R3: With `rst` and `clear_n` inactive and `load_n` low at a rising edge, `addr_q` takes the value of `ext_addr` sampled at that edge, whatever `count_n` is.
- R4: With `rst` low and `clear_n`, `load_n` and `count_n` all high at a rising edge, `addr_q` keeps its value and `ext_addr` has no effect.
- R5: With `rst` low, `clear_n` and `load_n` high and `count_n` low at a rising edge, `addr_q` becomes its previous value plus one.
- R6: A count step from the all-ones address (0x1FFFF for the default 17-bit width) gives 0.
- R7: `addr_q` changes only at a rising edge. Input changes between edges do not show on it until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| ext_addr | input | ADDR_W (17) | External address to capture |
| load_n | input | 1 | Active-low address strobe: capture `ext_addr` |
| count_n | input | 1 | Active-low count enable: step to the next address |
| clear_n | input | 1 | Active-low counter clear to address 0 |
| addr_q | output | ADDR_W (17) | Registered address presented to the array |

## Verification
The interesting coincidences are a load strobe and a count enable asserted at the same edge, and a clear asserted at the same edge as either of them. The bench drives every combination of the three controls, with random external addresses and random previous addresses. It predicts the winning action from the priority order and compares `addr_q` one edge later, so a counter that also stepped after a load, or loaded during a clear, gives a mismatch. The wrap case is set up by loading the all-ones address and then counting, and it is checked for both a plain count and a count that coincides with a load.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } burst_op_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic      clear_n,
  input  logic      load_n,
  input  logic      count_n,
  output burst_op_e op
);
  // Fixed priority: clear beats load beats count beats hold.
  always_comb begin
    if (!clear_n)      op = OP_CLEAR;
    else if (!load_n)  op = OP_LOAD;
    else if (!count_n) op = OP_INC;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  burst_op_e         op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  // The increment stays at ADDR_W bits, so all-ones rolls over to zero.
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_INC:   nxt = cur + STEP;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_reg.sv
module bac_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              count_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] addr_q
);
  typedef logic [ADDR_W-1:0] addr_t;

  burst_op_e op;
  addr_t     addr_d;

  bac_decode u_decode (
    .clear_n (clear_n),
    .load_n  (load_n),
    .count_n (count_n),
    .op      (op)
  );

  bac_next #(.ADDR_W(ADDR_W)) u_next (
    .op  (op),
    .cur (addr_q),
    .ext (ext_addr),
    .nxt (addr_d)
  );

  bac_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (addr_d),
    .q   (addr_q)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> addr_q == '0);  // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> addr_q == '0);  // R2
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !load_n) |=> addr_q == $past(ext_addr));  // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && count_n) |=> $stable(addr_q));  // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && !count_n) |=> addr_q == addr_t'($past(addr_q) + 1'b1));  // R5
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && !count_n && addr_q == '1) |=> addr_q == '0);  // R6
endmodule

// File: tb/tb_burst_addr_counter.sv
`timescale 1ns/1ps
module tb_burst_addr_counter;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          load_n, count_n, clear_n;
  logic [AW-1:0] addr_q;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [AW-1:0] exp_addr;

  always #5 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr),
    .load_n(load_n), .count_n(count_n), .clear_n(clear_n),
    .addr_q(addr_q)
  );

  task automatic check(input string tag, input logic [AW-1:0] want);
    tests++;
    if (addr_q !== want) begin
      fails++;
      $display("FAIL %s addr_q=%h expected=%h", tag, addr_q, want);
    end
  endtask

  // Drive at the falling edge, check stability mid-cycle (R7),
  // then check the result just after the rising edge.
  task automatic step(input logic r, input logic c, input logic l,
                      input logic n, input logic [AW-1:0] e);
    string tag;
    logic [AW-1:0] nxt;
    @(negedge clk);
    rst = r; clear_n = c; load_n = l; count_n = n; ext_addr = e;
    #1 check("R7", exp_addr);
    if (r)       begin nxt = '0;            tag = "R1"; end
    else if (!c) begin nxt = '0;            tag = "R2"; end
    else if (!l) begin nxt = e;             tag = "R3"; end
    else if (!n) begin nxt = exp_addr + 1'b1;
                       tag = (exp_addr == '1) ? "R6" : "R5"; end
    else         begin nxt = exp_addr;      tag = "R4"; end
    @(posedge clk);
    #1 check(tag, nxt);
    exp_addr = nxt;
  endtask

  initial begin
    rst = 1'b1; clear_n = 1'b1; load_n = 1'b1; count_n = 1'b1; ext_addr = '1;
    exp_addr = '0;
    repeat (2) @(posedge clk);
    #1 check("R1", '0);
    // R3 then R5 increments, R4 hold with changing ext_addr
    step(0, 1, 0, 1, 17'h00100);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 17'h1ABCD);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 17'(i * 977));
    // R6 wrap, plain and with a load coinciding
    step(0, 1, 0, 1, '1);
    step(0, 1, 1, 0, 17'h00055);
    step(0, 1, 1, 0, 17'h00055);
    step(0, 1, 0, 1, '1);
    step(0, 1, 0, 0, 17'h0AAAA);
    // R2 clear beats load and count; R1 reset beats everything
    step(0, 1, 0, 1, 17'h12345);
    step(0, 0, 0, 0, 17'h1FFFF);
    step(0, 1, 0, 1, 17'h0F0F0);
    step(1, 1, 0, 0, 17'h1FFFF);
    // Sweep every control combination many times with random data
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] ctl;
      ctl = 4'(k % 16);
      step(ctl[3] & (k % 7 == 0), ctl[2], ctl[1], ctl[0], 17'($urandom));
    end
    // Near-wrap walk
    step(0, 1, 0, 1, 17'h1FFFC);
    for (int i = 0; i < 8; i++) step(0, 1, 1, 0, '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog addr_q=%h expected=%h", addr_q, exp_addr);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule